// File: doc/BRIEF.md
# Single-Transfer AXI4-Lite Requester

This block lets local user logic perform an occasional register-style access on an AXI4-Lite bus without knowing the channel protocol. The user side raises a one-cycle request together with a direction bit, a word address, four byte-lane enables and 32 bits of write data. The block copies these fields into its own registers and runs exactly one AXI4-Lite transaction. It then signals completion with a one-cycle pulse, the returned read data and an error flag.

The data path is fixed at 32 bits, and each access moves one to four bytes. On writes the byte enables become the write strobes. On reads the byte lanes that are not enabled are returned as zero. Bursts are never issued, and only one transaction is ever in flight. The controller accepts any slave acknowledge timing, from the earliest cycle the protocol permits to long stalls on any channel.

Top module: `lite_single_master`

## Requirements
- R1: While reset is asserted and after it is released, with no request, all master VALID and READY outputs and `usr_done` are 0.
- R2: A write request accepted at a clock edge drives `m_awvalid` and `m_wvalid` high together from the next cycle, with `m_awaddr` equal to the request address, `m_wdata` equal to the write data and `m_wstrb` equal to the byte enables (bit i enables byte lane i, bits 8i+7..8i).
- R3: Each of `m_awvalid`, `m_wvalid` and `m_arvalid` stays high, with its address or data stable, until its own handshake cycle, and is low from the following cycle. The address and write data channels of a write finish independently.
- R4: `m_bready` goes high only after both write handshakes have occurred, and `usr_done` pulses in the cycle after the write response handshake, with `usr_err` equal to bit 1 of `m_bresp` (responses 2 and 3 are errors) and `usr_rdata` equal to 0.
- R5: A read request drives `m_arvalid` high from the next cycle, with `m_araddr` equal to the request address. `m_rready` goes high after the address handshake, and `usr_done` pulses in the cycle after the read data handshake.
- R6: On read completion, byte lane i of `usr_rdata` equals byte lane i of `m_rdata` when enable bit i was set and is 0 otherwise, and `usr_err` equals bit 1 of `m_rresp`.
- R7: A request raised while a transaction is in progress, including the completion cycle, is ignored: each access produces exactly one handshake on each channel it uses and none on the others.
- R8: The request fields are captured when the request is accepted. Changing the inputs afterwards does not change the address, strobes, data, direction or read-data masking of the access in progress.
- R9: `usr_done` is high for exactly one cycle per access, and the read channel and the write channels are never active at the same time.
- R10: Against a slave that acknowledges at the earliest allowed cycles, `usr_done` is high in the third cycle after the cycle in which the request was accepted, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | Request strobe, accepted only when idle |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_addr | input | ADDR_W | Byte address of the access |
| usr_be | input | 4 | Byte-lane enables |
| usr_wdata | input | 32 | Write data |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_rdata | output | 32 | Masked read data (0 after a write) |
| usr_err | output | 1 | Error response flag |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench builds the block with the default 32-bit address width, so real upper address bits are carried and compared on both address channels. Its slave model takes a separate stall count for the write address, write data and response channels from each table row. Zero stalls bring the earliest-acknowledge latency within reach. Skewed counts make one write channel finish well before the other, in either order. All four response codes and partial byte-enable patterns are covered, so the error flag and the per-lane read masking are both exercised.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WADDR = 3'd1,
    ST_WRESP = 3'd2,
    ST_RADDR = 3'd3,
    ST_RDATA = 3'd4,
    ST_DONE  = 3'd5
  } lsm_state_e;
endpackage

// File: rtl/lsm_req_latch.sv
module lsm_req_latch
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              d_write,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [STRB_W-1:0] d_be,
  input  logic [DATA_W-1:0] d_wdata,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic [STRB_W-1:0] q_be,
  output logic [DATA_W-1:0] q_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_addr  <= '0;
      q_be    <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= d_write;
      q_addr  <= d_addr;
      q_be    <= d_be;
      q_wdata <= d_wdata;
    end
  end

  // R8
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_addr) && $stable(q_be) && $stable(q_wdata) && $stable(q_write));
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_write,
  output logic load,
  output logic fin,
  output logic awvalid,
  input  logic awready,
  output logic wvalid,
  input  logic wready,
  input  logic bvalid,
  output logic bready,
  output logic arvalid,
  input  logic arready,
  input  logic rvalid,
  output logic rready
);
  lsm_state_e state_q, state_d;
  logic aw_ok_q, aw_ok_d;
  logic w_ok_q, w_ok_d;

  always_comb begin
    state_d = state_q;
    aw_ok_d = aw_ok_q;
    w_ok_d  = w_ok_q;
    load    = 1'b0;
    fin     = 1'b0;
    awvalid = 1'b0;
    wvalid  = 1'b0;
    bready  = 1'b0;
    arvalid = 1'b0;
    rready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          load    = 1'b1;
          state_d = req_write ? ST_WADDR : ST_RADDR;
        end
      end
      ST_WADDR: begin
        awvalid = !aw_ok_q;
        wvalid  = !w_ok_q;
        aw_ok_d = aw_ok_q | awready;
        w_ok_d  = w_ok_q | wready;
        if (aw_ok_d && w_ok_d) begin
          state_d = ST_WRESP;
          aw_ok_d = 1'b0;
          w_ok_d  = 1'b0;
        end
      end
      ST_WRESP: begin
        bready = 1'b1;
        if (bvalid) begin
          fin     = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_RADDR: begin
        arvalid = 1'b1;
        if (arready) state_d = ST_RDATA;
      end
      ST_RDATA: begin
        rready = 1'b1;
        if (rvalid) begin
          fin     = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      aw_ok_q <= 1'b0;
      w_ok_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      aw_ok_q <= aw_ok_d;
      w_ok_q  <= w_ok_d;
    end
  end

  // R3
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid);
  // R3
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid);
  // R3
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid);
  // R3
  aw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready |=> !awvalid);
  // R9
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((arvalid || rready) && (awvalid || wvalid || bready)));
  // R7
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || wvalid || bready || arvalid || rready) |-> !load);
endmodule

// File: rtl/lsm_resp.sv
module lsm_resp
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic              is_write,
  input  logic [STRB_W-1:0] be,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic [1:0]        bresp,
  output logic              done,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err
);
  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign masked[i*8 +: 8] = be[i] ? rdata[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rdata_q <= '0;
      err     <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        rdata_q <= is_write ? '0 : masked;
        err     <= is_write ? bresp[1] : rresp[1];
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/lite_single_master.sv
module lite_single_master
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_req,
  input  logic              usr_write,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [3:0]        usr_be,
  input  logic [31:0]       usr_wdata,
  output logic              usr_done,
  output logic [31:0]       usr_rdata,
  output logic              usr_err,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [31:0]       m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready
);
  logic              load, fin;
  logic              cap_write;
  logic [ADDR_W-1:0] cap_addr;
  logic [STRB_W-1:0] cap_be;
  logic [DATA_W-1:0] cap_wdata;

  lsm_req_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load),
    .d_write(usr_write), .d_addr(usr_addr), .d_be(usr_be), .d_wdata(usr_wdata),
    .q_write(cap_write), .q_addr(cap_addr), .q_be(cap_be), .q_wdata(cap_wdata)
  );

  lsm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(usr_req), .req_write(usr_write),
    .load(load), .fin(fin),
    .awvalid(m_awvalid), .awready(m_awready),
    .wvalid(m_wvalid), .wready(m_wready),
    .bvalid(m_bvalid), .bready(m_bready),
    .arvalid(m_arvalid), .arready(m_arready),
    .rvalid(m_rvalid), .rready(m_rready)
  );

  lsm_resp u_resp (
    .clk(clk), .rst_n(rst_n), .fin(fin), .is_write(cap_write), .be(cap_be),
    .rdata(m_rdata), .rresp(m_rresp), .bresp(m_bresp),
    .done(usr_done), .rdata_q(usr_rdata), .err(usr_err)
  );

  assign m_awaddr = cap_addr;
  assign m_araddr = cap_addr;
  assign m_wdata  = cap_wdata;
  assign m_wstrb  = cap_be;

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |-> $past((m_bvalid && m_bready) || (m_rvalid && m_rready)));
  // R3
  awaddr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> $stable(m_awaddr));
  // R3
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> $stable(m_wdata) && $stable(m_wstrb));
  // R3
  araddr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> $stable(m_araddr));
endmodule

// File: tb/lite_single_master_bench.sv
module lite_single_master_bench;
  localparam int ADDR_W = 32;
  localparam logic [31:0] KEY = 32'h5A5A_A5A5;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  resp;
    logic [2:0]  da;
    logic [2:0]  dw;
    logic [2:0]  dr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h8000_1000, 4'hF, 32'hDEAD_BEEF, 2'd0, 3'd0, 3'd0, 3'd0},
    '{1'b0, 32'h0000_2004, 4'hF, 32'h0,         2'd0, 3'd0, 3'd0, 3'd0},
    '{1'b1, 32'h0000_0010, 4'h1, 32'h1122_3344, 2'd2, 3'd3, 3'd0, 3'd2},
    '{1'b1, 32'hF000_0014, 4'hC, 32'h5566_7788, 2'd0, 3'd0, 3'd4, 3'd1},
    '{1'b0, 32'h0000_0020, 4'h3, 32'h0,         2'd2, 3'd2, 3'd0, 3'd3},
    '{1'b0, 32'h1234_5624, 4'h6, 32'h0,         2'd3, 3'd5, 3'd0, 3'd0},
    '{1'b1, 32'h0000_0028, 4'h2, 32'hCAFE_F00D, 2'd3, 3'd2, 3'd2, 3'd0},
    '{1'b0, 32'h0000_002C, 4'h8, 32'h0,         2'd1, 3'd0, 3'd0, 3'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              usr_req = 1'b0, usr_write = 1'b0;
  logic [ADDR_W-1:0] usr_addr = '0;
  logic [3:0]        usr_be = '0;
  logic [31:0]       usr_wdata = '0;
  logic              usr_done, usr_err;
  logic [31:0]       usr_rdata;
  logic [ADDR_W-1:0] m_awaddr, m_araddr;
  logic              m_awvalid, m_awready, m_wvalid, m_wready, m_bready;
  logic              m_arvalid, m_arready, m_rready;
  logic [31:0]       m_wdata;
  logic [3:0]        m_wstrb;
  logic [1:0]        m_bresp, m_rresp;
  logic              m_bvalid, m_rvalid;
  logic [31:0]       m_rdata;

  lite_single_master #(.ADDR_W(ADDR_W)) u_lite_single_master (
    .clk(clk), .rst_n(rst_n),
    .usr_req(usr_req), .usr_write(usr_write), .usr_addr(usr_addr),
    .usr_be(usr_be), .usr_wdata(usr_wdata),
    .usr_done(usr_done), .usr_rdata(usr_rdata), .usr_err(usr_err),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  // slave model
  logic [2:0] cfg_da = '0, cfg_dw = '0, cfg_dr = '0;
  logic [1:0] cfg_resp = '0;
  logic [3:0] aw_cnt, w_cnt, ar_cnt, b_cnt, r_cnt;
  logic aw_s, w_s, r_pend;
  logic [31:0] slv_addr;
  int n_aw, n_w, n_b, n_ar, n_r;
  logic [31:0] got_awaddr, got_wdata, got_araddr;
  logic [3:0]  got_wstrb;
  logic        bad_bready;

  wire aw_hs = m_awvalid && m_awready;
  wire w_hs  = m_wvalid && m_wready;
  wire ar_hs = m_arvalid && m_arready;
  assign m_awready = m_awvalid && (aw_cnt >= {1'b0, cfg_da});
  assign m_wready  = m_wvalid && (w_cnt >= {1'b0, cfg_dw});
  assign m_arready = m_arvalid && (ar_cnt >= {1'b0, cfg_da});

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_cnt <= '0; w_cnt <= '0; ar_cnt <= '0; b_cnt <= '0; r_cnt <= '0;
      aw_s <= 1'b0; w_s <= 1'b0; r_pend <= 1'b0; slv_addr <= '0;
      m_bvalid <= 1'b0; m_bresp <= '0; m_rvalid <= 1'b0; m_rresp <= '0; m_rdata <= '0;
      n_aw <= 0; n_w <= 0; n_b <= 0; n_ar <= 0; n_r <= 0;
      got_awaddr <= '0; got_wdata <= '0; got_araddr <= '0; got_wstrb <= '0;
      bad_bready <= 1'b0;
    end else begin
      aw_cnt <= (m_awvalid && !m_awready) ? aw_cnt + 4'd1 : 4'd0;
      w_cnt  <= (m_wvalid && !m_wready) ? w_cnt + 4'd1 : 4'd0;
      ar_cnt <= (m_arvalid && !m_arready) ? ar_cnt + 4'd1 : 4'd0;
      if (aw_hs) begin n_aw <= n_aw + 1; got_awaddr <= m_awaddr; end
      if (w_hs)  begin n_w <= n_w + 1; got_wdata <= m_wdata; got_wstrb <= m_wstrb; end
      if (ar_hs) begin n_ar <= n_ar + 1; got_araddr <= m_araddr; end
      if (m_bready && !((aw_s || aw_hs) && (w_s || w_hs)) && !(aw_s && w_s))
        bad_bready <= 1'b1;
      // write response
      if (m_bvalid && m_bready) begin
        m_bvalid <= 1'b0; aw_s <= 1'b0; w_s <= 1'b0; b_cnt <= '0; n_b <= n_b + 1;
      end else if ((aw_s || aw_hs) && (w_s || w_hs) && !m_bvalid) begin
        aw_s <= 1'b1; w_s <= 1'b1;
        if (b_cnt >= {1'b0, cfg_dr}) begin m_bvalid <= 1'b1; m_bresp <= cfg_resp; end
        else b_cnt <= b_cnt + 4'd1;
      end else begin
        aw_s <= aw_s || aw_hs; w_s <= w_s || w_hs;
      end
      // read data
      if (m_rvalid && m_rready) begin
        m_rvalid <= 1'b0; r_pend <= 1'b0; r_cnt <= '0; n_r <= n_r + 1;
      end else if ((r_pend || ar_hs) && !m_rvalid) begin
        if (ar_hs) slv_addr <= m_araddr;
        r_pend <= 1'b1;
        if (r_cnt >= {1'b0, cfg_dr}) begin
          m_rvalid <= 1'b1; m_rresp <= cfg_resp;
          m_rdata  <= (ar_hs ? m_araddr : slv_addr) ^ KEY;
        end else r_cnt <= r_cnt + 4'd1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int cyc;
    int b_aw, b_w, b_b, b_ar, b_r;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready && !usr_done,
        "R1 reset", {59'd0, m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready && !usr_done,
        "R1 idle", {59'd0, m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 64'd0);
    chk(n_aw + n_w + n_ar == 0, "R1 no traffic", 64'(n_aw + n_w + n_ar), 64'd0);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      cfg_da = v.da; cfg_dw = v.dw; cfg_dr = v.dr; cfg_resp = v.resp;
      b_aw = n_aw; b_w = n_w; b_b = n_b; b_ar = n_ar; b_r = n_r;
      usr_req = 1'b1; usr_write = v.wr; usr_addr = v.addr; usr_be = v.be; usr_wdata = v.data;
      @(posedge clk);
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
        if (cyc == 1) begin
          if (v.wr) chk(m_awvalid && m_wvalid && !m_arvalid, "R2 valids together",
                        {61'd0, m_awvalid, m_wvalid, m_arvalid}, 64'd6);
          else      chk(m_arvalid && !m_awvalid && !m_wvalid, "R5 arvalid",
                        {61'd0, m_awvalid, m_wvalid, m_arvalid}, 64'd1);
        end
        // R7 / R8: stray request with altered fields while busy
        usr_req = (cyc <= 2); usr_write = ~v.wr; usr_addr = ~v.addr;
        usr_be = ~v.be; usr_wdata = ~v.data;
      end while (!usr_done && cyc < 80);
      usr_req = 1'b0;
      chk(usr_done, "R5 done seen", {63'd0, usr_done}, 64'd1);
      if (v.da == 0 && v.dw == 0 && v.dr == 0)
        chk(cyc == 3, "R10 earliest latency", 64'(cyc), 64'd3);
      chk(usr_err == v.resp[1], v.wr ? "R4 write err" : "R6 read err",
          {63'd0, usr_err}, {63'd0, v.resp[1]});
      if (v.wr) begin
        chk(got_awaddr == v.addr, "R8 awaddr", {32'd0, got_awaddr}, {32'd0, v.addr});
        chk(got_wdata == v.data && got_wstrb == v.be, "R2 wdata/wstrb",
            {28'd0, got_wstrb, got_wdata}, {28'd0, v.be, v.data});
        chk(usr_rdata == 32'd0, "R4 rdata zero", {32'd0, usr_rdata}, 64'd0);
        chk(n_aw - b_aw == 1 && n_w - b_w == 1 && n_b - b_b == 1 && n_ar == b_ar,
            "R7 one write", 64'(n_aw - b_aw + n_w - b_w + n_b - b_b), 64'd3);
        chk(!bad_bready, "R4 bready order", {63'd0, bad_bready}, 64'd0);
      end else begin
        chk(got_araddr == v.addr, "R8 araddr", {32'd0, got_araddr}, {32'd0, v.addr});
        chk(usr_rdata == lane_mask(v.addr ^ KEY, v.be), "R6 masked rdata",
            {32'd0, usr_rdata}, {32'd0, lane_mask(v.addr ^ KEY, v.be)});
        chk(n_ar - b_ar == 1 && n_r - b_r == 1 && n_aw == b_aw && n_w == b_w,
            "R7 one read", 64'(n_ar - b_ar + n_r - b_r), 64'd2);
      end
      @(negedge clk);
      chk(!usr_done, "R9 done one cycle", {63'd0, usr_done}, 64'd0);
      chk(!m_awvalid && !m_wvalid && !m_arvalid, "R3 valids dropped",
          {61'd0, m_awvalid, m_wvalid, m_arvalid}, 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule